// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does so by reading two levels of translation tables from memory. A requester presents an address and an access kind (load, store or instruction fetch) while the walker is idle. The walker then reads one word from a first-level directory, whose location comes from a root base input. It follows that word to a second-level table and reads the leaf word there.

The walker checks the leaf against the access kind. It then either returns the physical page number joined with the untouched page offset, or it raises a fault with a code. A fault code says whether the page is absent or the access is not permitted. Only one walk is in flight at a time. Memory reads use a request/grant/response port that tolerates stalls and any response latency.

Top module: `pt_walker`

## Requirements
- R1: On success, `paddr_o[31:12]` is the leaf's bits 31:12 and `paddr_o[11:0]` equals bits 11:0 of the accepted virtual address.
- R2: The first memory read is at `base + 4*vaddr[31:22]`, where `base_i` is sampled in the acceptance cycle; later changes to `base_i` have no effect on that walk.
- R3: The second memory read is at `{dir_word[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: Entry layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 dirty, bits 31:12 page frame. On success, `attr_o` carries leaf bits 11:0 unchanged. The dirty bit and the spare bits never affect the outcome.
- R5: A directory word with bit 0 clear ends the walk with a page fault (code 1) after exactly one memory read.
- R6: A leaf word with bit 0 clear ends the walk with a page fault (code 1), whatever its permission bits are.
- R7: Access kinds are 0 = load (needs read), 1 = store (needs write) and 2 = fetch (needs execute). A valid leaf that lacks the needed bit ends the walk with a permission fault (code 2). Kind 3 always gives a permission fault.
- R8: `done_o` and `fault_o` are single-cycle pulses that never occur together. `fault_code_o` is 0 except while `fault_o` is high.
- R9: `busy_o` is high and `req_ready_o` low from the cycle after acceptance through the done/fault cycle. Requests presented while busy are ignored.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_gnt_i`. The read data is taken in the cycle `mem_rvalid_i` is high, after any delay.
- R11: After reset the walker is idle: ready high, and busy, memory request, done and fault low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| base_i | input | 32 | Byte address of the first-level directory |
| req_ready_o | output | 1 | Walker idle; a request is taken this cycle |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | 32 | Byte address of the word to read |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| done_o | output | 1 | Translation succeeded (one cycle) |
| fault_o | output | 1 | Walk ended with a fault (one cycle) |
| fault_code_o | output | 2 | 1 page not present, 2 permission denied |
| paddr_o | output | 32 | Physical address, valid with done_o |
| attr_o | output | 12 | Leaf attribute bits 11:0, valid with done_o |

## Verification
The hardest situations to reach from the ports are two kinds of stall. In one, the memory withholds its grant while the root base input changes under a pending directory read. In the other, a new request is held on the input for the whole walk and must be dropped. The stimulus reaches both by gating the bench memory's grant and by stretching its response latency. It watches the held address and the read count over those stretched windows. The table-driven part pairs entries so that the same leaf is hit with every access kind. It also places an invalid leaf with permission bits set, so that a page fault must win over a permission fault.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_TBL,
    ST_WT_TBL,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PERM = 2'd2
  } flt_e;

  localparam int ENT_V = 0;
  localparam int ENT_R = 1;
  localparam int ENT_W = 2;
  localparam int ENT_X = 3;
  localparam int ENT_FLAGS = 4;

endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
  parameter int AW     = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [LVL_W-1:0]    lvl_i,
  input  logic [AW-1:0]       root_i,
  input  logic [AW-OFF_W-1:0] tbl_frame_i,
  input  logic [AW-1:0]       va_i,
  output logic [AW-1:0]       addr_o
);

  localparam int PAD_W = AW - IDX_W - 2;

  logic [IDX_W-1:0] idx [LEVELS];
  logic [AW-1:0]    lvl_base;

  // per-level index, top level takes the most significant slice
  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx[l] = va_i[AW-1-l*IDX_W -: IDX_W];
  end

  assign lvl_base = (lvl_i == '0) ? root_i : {tbl_frame_i, {OFF_W{1'b0}}};
  assign addr_o   = lvl_base + {{PAD_W{1'b0}}, idx[lvl_i], 2'b00};

endmodule

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
  import pt_walker_pkg::*;
(
  input  logic [ENT_FLAGS-1:0] ent_i,
  input  acc_e                 acc_i,
  output logic                 valid_o,
  output logic                 allowed_o
);

  assign valid_o = ent_i[ENT_V];

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  allowed_o = ent_i[ENT_R];
      ACC_STORE: allowed_o = ent_i[ENT_W];
      ACC_FETCH: allowed_o = ent_i[ENT_X];
      default:   allowed_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic        ent_valid_i,
  input  logic        ent_allowed_i,
  output walk_state_e state_o,
  output logic        accept_o,
  output logic        dir_take_o,
  output logic        leaf_take_o,
  output flt_e        flt_o
);

  walk_state_e state_q, state_d;
  flt_e        flt_q, flt_d;

  assign accept_o    = (state_q == ST_IDLE) && req_valid_i;
  assign dir_take_o  = (state_q == ST_WT_DIR) && mem_rvalid_i && ent_valid_i;
  assign leaf_take_o = (state_q == ST_WT_TBL) && mem_rvalid_i && ent_valid_i && ent_allowed_i;

  always_comb begin
    state_d = state_q;
    flt_d   = flt_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_gnt_i) state_d = ST_WT_DIR;
      ST_WT_DIR: begin
        if (mem_rvalid_i) begin
          if (ent_valid_i) begin
            state_d = ST_RD_TBL;
          end else begin
            state_d = ST_FAULT;
            flt_d   = FLT_PAGE;
          end
        end
      end
      ST_RD_TBL: if (mem_gnt_i) state_d = ST_WT_TBL;
      ST_WT_TBL: begin
        if (mem_rvalid_i) begin
          // absence outranks permission
          if (!ent_valid_i) begin
            state_d = ST_FAULT;
            flt_d   = FLT_PAGE;
          end else if (!ent_allowed_i) begin
            state_d = ST_FAULT;
            flt_d   = FLT_PERM;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_DONE:   state_d = ST_IDLE;
      ST_FAULT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flt_q   <= FLT_NONE;
    end else begin
      state_q <= state_d;
      flt_q   <= flt_d;
    end
  end

  assign state_o = state_q;
  assign flt_o   = flt_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int AW     = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2,
  localparam int FRM_W = AW - OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_vaddr_i,
  input  logic [1:0]       req_acc_i,
  input  logic [AW-1:0]    base_i,
  output logic             req_ready_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic [AW-1:0]    paddr_o,
  output logic [OFF_W-1:0] attr_o
);

  walk_state_e       state;
  flt_e              flt;
  logic              accept, dir_take, leaf_take;
  logic              ent_valid, ent_allowed;
  logic [AW-1:0]     va_q, root_q;
  acc_e              acc_q;
  logic [FRM_W-1:0]  tbl_frame_q, leaf_frame_q;
  logic [OFF_W-1:0]  attr_q;
  logic [LVL_W-1:0]  lvl;

  pt_walker_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .mem_gnt_i     (mem_gnt_i),
    .mem_rvalid_i  (mem_rvalid_i),
    .ent_valid_i   (ent_valid),
    .ent_allowed_i (ent_allowed),
    .state_o       (state),
    .accept_o      (accept),
    .dir_take_o    (dir_take),
    .leaf_take_o   (leaf_take),
    .flt_o         (flt)
  );

  pt_walker_perm u_perm (
    .ent_i     (mem_rdata_i[ENT_FLAGS-1:0]),
    .acc_i     (acc_q),
    .valid_o   (ent_valid),
    .allowed_o (ent_allowed)
  );

  assign lvl = (state == ST_RD_TBL) ? LVL_W'(1) : '0;

  pt_walker_addr #(
    .AW     (AW),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .LEVELS (LEVELS)
  ) u_addr (
    .lvl_i       (lvl),
    .root_i      (root_q),
    .tbl_frame_i (tbl_frame_q),
    .va_i        (va_q),
    .addr_o      (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q         <= '0;
      root_q       <= '0;
      acc_q        <= ACC_LOAD;
      tbl_frame_q  <= '0;
      leaf_frame_q <= '0;
      attr_q       <= '0;
    end else begin
      if (accept) begin
        va_q   <= req_vaddr_i;
        root_q <= base_i;
        acc_q  <= acc_e'(req_acc_i);
      end
      if (dir_take) tbl_frame_q <= mem_rdata_i[AW-1:OFF_W];
      if (leaf_take) begin
        leaf_frame_q <= mem_rdata_i[AW-1:OFF_W];
        attr_q       <= mem_rdata_i[OFF_W-1:0];
      end
    end
  end

  assign req_ready_o  = (state == ST_IDLE);
  assign busy_o       = (state != ST_IDLE);
  assign mem_req_o    = (state == ST_RD_DIR) || (state == ST_RD_TBL);
  assign done_o       = (state == ST_DONE);
  assign fault_o      = (state == ST_FAULT);
  assign fault_code_o = fault_o ? flt : FLT_NONE;
  assign paddr_o      = {leaf_frame_q, va_q[OFF_W-1:0]};
  assign attr_o       = attr_q;

endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [11:0] req_off_i,
  input logic [1:0]  req_acc_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic        mem_gnt_i,
  input logic [31:0] mem_addr_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [1:0]  fault_code_o,
  input logic [11:0] paddr_off_i,
  input logic [2:0]  perm_i
);

  logic [11:0] cap_off;
  logic [1:0]  cap_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_off <= '0;
      cap_acc <= '0;
    end else if (req_valid_i && req_ready_o) begin
      cap_off <= req_off_i;
      cap_acc <= req_acc_i;
    end
  end

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> paddr_off_i == cap_off); // R1

  AST_PERM_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((cap_acc == 2'd0 && perm_i[0]) || (cap_acc == 2'd1 && perm_i[1]) ||
                (cap_acc == 2'd2 && perm_i[2]))); // R7

  AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_code_o == 2'd1 || fault_code_o == 2'd2)); // R8

  AST_CODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> fault_code_o == 2'd0); // R8

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_FAULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o); // R8

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !busy_o)); // R11

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o))); // R10

endmodule

bind pt_walker pt_walker_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_off_i    (req_vaddr_i[11:0]),
  .req_acc_i    (req_acc_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_addr_o   (mem_addr_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_code_o (fault_code_o),
  .paddr_off_i  (paddr_o[11:0]),
  .perm_i       (attr_o[3:1])
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [1:0]  code;
    logic [31:0] pa;
    logic [2:0]  perm;  // {X,W,R}
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{32'h00000ABC, 2'd0, 2'd0, 32'hC20A3ABC, 3'b101, 2'd2},
    '{32'h00000123, 2'd2, 2'd0, 32'hC20A3123, 3'b101, 2'd2},
    '{32'h00000FFF, 2'd1, 2'd2, 32'h0,        3'b000, 2'd2},
    '{32'h00001004, 2'd1, 2'd0, 32'h10045004, 3'b011, 2'd2},
    '{32'h00001008, 2'd2, 2'd2, 32'h0,        3'b000, 2'd2},
    '{32'h00002FFC, 2'd2, 2'd0, 32'h4123BFFC, 3'b111, 2'd2},
    '{32'h00003000, 2'd0, 2'd1, 32'h0,        3'b000, 2'd2},
    '{32'h00400000, 2'd0, 2'd1, 32'h0,        3'b000, 2'd1},
    '{32'h00801010, 2'd1, 2'd0, 32'h10045010, 3'b011, 2'd2},
    '{32'h00004777, 2'd0, 2'd2, 32'h0,        3'b000, 2'd2},
    '{32'h00002000, 2'd3, 2'd2, 32'h0,        3'b000, 2'd2},
    '{32'hFFC00000, 2'd0, 2'd1, 32'h0,        3'b000, 2'd1},
    '{32'h00002000, 2'd1, 2'd0, 32'h4123B000, 3'b111, 2'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic [31:0] base_i = '0;
  logic        req_ready_o, busy_o, mem_req_o, mem_gnt_i, mem_rvalid_i;
  logic [31:0] mem_addr_o, mem_rdata_i, paddr_o;
  logic        done_o, fault_o;
  logic [1:0]  fault_code_o;
  logic [11:0] attr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  pt_walker uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_vaddr_i  (req_vaddr_i),
    .req_acc_i    (req_acc_i),
    .base_i       (base_i),
    .req_ready_o  (req_ready_o),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .paddr_o      (paddr_o),
    .attr_o       (attr_o)
  );

  // memory model: grant gate, programmable latency, read log
  logic [31:0] mem_q [0:2047];
  logic [31:0] alog [0:255];
  logic [31:0] rdata_q = '0;
  logic        gnt_en = 1'b1;
  int          lat = 1;
  int          pend = 0;
  int          rd_tot = 0;

  assign mem_gnt_i    = mem_req_o & gnt_en;
  assign mem_rvalid_i = (pend == 1);
  assign mem_rdata_i  = rdata_q;

  always @(posedge clk_i) begin
    if (mem_req_o && mem_gnt_i) begin
      alog[rd_tot[7:0]] = mem_addr_o;
      rd_tot = rd_tot + 1;
      rdata_q <= mem_q[mem_addr_o[12:2]];
      pend    <= lat;
    end else if (pend > 0) begin
      pend <= pend - 1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wait_end(output logic ok);
    int n;
    n = 0;
    while (!(done_o || fault_o) && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    ok = (n < 200);
    if (!ok) chk("R8 walk never ended", 32'd0, 32'd1);
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                      output logic gd, output logic [1:0] cd, output logic [31:0] pa,
                      output logic [11:0] at, output int nrd,
                      output logic [31:0] a1, output logic [31:0] a2);
    int   start;
    logic ok;
    start = rd_tot;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    req_acc_i   = acc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_end(ok);
    gd  = done_o;
    cd  = fault_code_o;
    pa  = paddr_o;
    at  = attr_o;
    nrd = rd_tot - start;
    a1  = alog[start[7:0]];
    a2  = alog[8'(start + 1)];
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic        gd, ok;
    logic [1:0]  cd;
    logic [31:0] pa, a1, a2;
    logic [11:0] at;
    int          nr, snap;

    for (int i = 0; i < 2048; i++) mem_q[i] = '0;
    mem_q[0]     = 32'h00001001;  // dir[0] -> table at 0x1000
    mem_q[2]     = 32'h00001001;  // dir[2] aliases same table
    mem_q[11'h200] = 32'h00001001;  // dir[0] for root 0x800
    mem_q[11'h400] = 32'hC20A300B;  // V R X
    mem_q[11'h401] = 32'h10045007;  // V R W
    mem_q[11'h402] = 32'h4123B01F;  // V R W X D
    mem_q[11'h403] = 32'h10044006;  // R W but not valid
    mem_q[11'h404] = 32'h00055001;  // valid, no permissions

    // R11: reset state
    repeat (3) @(negedge clk_i);
    chk("R11 ready in reset", req_ready_o, 1);
    chk("R11 busy in reset", busy_o, 0);
    chk("R11 mem_req in reset", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 ready after reset", req_ready_o, 1);
    chk("R11 done/fault after reset", {done_o, fault_o}, 0);

    // table-driven walks
    for (int i = 0; i < NV; i++) begin
      walk(VEC[i].va, VEC[i].acc, gd, cd, pa, at, nr, a1, a2);
      chk($sformatf("R2 v%0d dir addr", i), a1, {20'h0, VEC[i].va[31:22], 2'b00});
      chk($sformatf("R5 v%0d read count", i), nr, VEC[i].nrd);
      if (VEC[i].nrd == 2)
        chk($sformatf("R3 v%0d tbl addr", i), a2, 32'h1000 + {20'h0, VEC[i].va[21:12], 2'b00});
      if (VEC[i].code == 2'd0) begin
        chk($sformatf("R8 v%0d done", i), gd, 1);
        chk($sformatf("R1 v%0d paddr", i), pa, VEC[i].pa);
        chk($sformatf("R4 v%0d attr perm", i), at[3:1], VEC[i].perm);
      end else begin
        chk($sformatf("R6 v%0d no done", i), gd, 0);
        chk($sformatf("R7 v%0d fault code", i), cd, VEC[i].code);
      end
      @(negedge clk_i);
      chk($sformatf("R8 v%0d pulse width", i), {done_o, fault_o}, 0);
    end
    chk("R4 dirty attr seen", at[4], 1);

    // R9: busy and ignored request during a walk
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vaddr_i = 32'h00001004;
    req_acc_i   = 2'd1;
    snap = rd_tot;
    @(negedge clk_i);
    chk("R9 busy after accept", busy_o, 1);
    chk("R9 ready low after accept", req_ready_o, 0);
    req_vaddr_i = 32'h00000ABC;
    req_acc_i   = 2'd0;
    wait_end(ok);
    req_valid_i = 1'b0;
    chk("R9 busy at done", busy_o, 1);
    chk("R9 held request ignored paddr", paddr_o, 32'h10045004);
    chk("R9 held request ignored attr", attr_o[3:1], 3'b011);
    repeat (3) @(negedge clk_i);
    chk("R9 idle after done", {busy_o, req_ready_o}, 2'b01);
    chk("R9 no extra reads", rd_tot - snap, 2);

    // R10 and R2: grant stall, long latency, base changed after accept
    gnt_en = 1'b0;
    lat    = 4;
    base_i = 32'h00000800;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vaddr_i = 32'h00001FFC;
    req_acc_i   = 2'd0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    base_i      = 32'h00000000;
    for (int k = 0; k < 4; k++) begin
      chk("R10 request held", mem_req_o, 1);
      chk("R2 base sampled at accept", mem_addr_o, 32'h00000800);
      @(negedge clk_i);
    end
    gnt_en = 1'b1;
    wait_end(ok);
    chk("R10 stalled walk done", done_o, 1);
    chk("R1 stalled walk paddr", paddr_o, 32'h10045FFC);
    lat = 1;
    @(negedge clk_i);

    // R5 under long latency: invalid directory, single read
    lat = 3;
    walk(32'h00400ABC, 2'd2, gd, cd, pa, at, nr, a1, a2);
    chk("R5 slow invalid dir fault", cd, 2'd1);
    chk("R5 slow invalid dir reads", nr, 1);
    lat = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule